// File: doc/BRIEF.md
# Microprogram Sequencer with Conditional and Dispatch Branching

This block is the control unit of a microcoded processor. It holds a writable control store of 512 words of 36 bits, a microprogram counter and a microinstruction register. The store is filled through a simple write port, normally while reset is held. After reset the block steps through the microprogram. Each microinstruction is presented to the data path for one execute cycle, and its fields drive the ALU/shift control lines, the register write enables, the memory strobes and a one-hot B-bus source enable. The source enable is decoded from a 4-bit select code.

Each microinstruction names its successor. The block copies the successor field into the counter and modifies it at the same time under three jump bits. Two of them OR the captured sign flag or the captured zero flag into the top address bit, which gives a two-way conditional branch. The third ORs an 8-bit byte from the data path into the low eight address bits, which gives a 256-way opcode dispatch. The flags are captured from the data path at the end of the execute cycle. The next address is formed only after that capture, in a following advance cycle.

Top module: `micro_sequencer`

## Requirements
- R1: While reset is low, the counter `cur_addr` is 0, `exec_valid` is 0 and every control output is 0. On the first clock edge after reset is released, the word at address 0 is loaded and shown in an execute cycle.
- R2: Each microinstruction takes two cycles. First comes an execute cycle with `exec_valid` = 1, then an advance cycle with `exec_valid` = 0. During the execute cycle, `cur_addr` shows the address of the word being executed.
- R3: A word is laid out from bit 35 down as follows: successor address [35:27], dispatch bit [26], sign-jump bit [25], zero-jump bit [24], ALU/shift control [23:16], write enables [15:7], memory write [6], memory read [5], fetch [4], B select [3:0]. When bits [26:24] are all zero, the next address is exactly the successor field.
- R4: When the zero-jump bit is set, bit 8 of the next address is successor[8] ORed with the `alu_zero` value sampled at the end of the execute cycle.
- R5: When the sign-jump bit is set, bit 8 of the next address is successor[8] ORed with the `alu_neg` value sampled at the end of the execute cycle.
- R6: When both jump bits are set, bit 8 of the next address is successor[8] OR (zero-jump AND Z) OR (sign-jump AND N).
- R7: When the dispatch bit is set, bits [7:0] of the next address are successor[7:0] ORed with `mbr_byte` as presented during the advance cycle. When it is clear, the byte has no effect.
- R8: During an execute cycle, B select code k in 0..8 drives bit k of `b_drive_en`, and only that bit. Codes 9 to 15 drive no bit.
- R9: During an execute cycle, `alu_ctl`, `c_wr_en` and the three memory strobes equal their word fields. In all other cycles they are 0, and so is `b_drive_en`.
- R10: A word written through the write port at an address is the word executed when the counter next reaches that address.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| cs_we | input | 1 | Control store write strobe |
| cs_waddr | input | 9 | Control store write address |
| cs_wdata | input | 36 | Control store write data |
| alu_neg | input | 1 | ALU result negative, captured at end of execute cycle |
| alu_zero | input | 1 | ALU result zero, captured at end of execute cycle |
| mbr_byte | input | 8 | Byte register value used for dispatch |
| exec_valid | output | 1 | High in execute cycles |
| cur_addr | output | 9 | Microprogram counter |
| alu_ctl | output | 8 | ALU and shifter control lines |
| c_wr_en | output | 9 | Register write enables from the C bus |
| mem_write | output | 1 | Word memory write strobe |
| mem_read | output | 1 | Word memory read strobe |
| mem_fetch | output | 1 | Byte fetch strobe |
| b_drive_en | output | 9 | One-hot B-bus source enable |

## Verification
The hardest situations to reach from the ports are successor addresses that depend on all three jump bits at once, with flags and dispatch bytes that differ from one step to the next. The bench fills all 512 words with an arithmetic pattern in which the jump bits, successor, select code and other fields vary with the address. It then lets the microprogram run freely for many steps, driving pseudo-random flags and bytes with all-ones bytes mixed in. At every step it predicts the next address from its own copy of the pattern. A final directed case rewrites word 0 with every jump bit set and an unused select code, and checks the dispatch result.

// File: rtl/useq_pkg.sv
`timescale 1ns/1ps
package useq_pkg;
    parameter int ADDR_W = 9;
    parameter int BYTE_W = ADDR_W - 1;
    parameter int JAM_W  = 3;
    parameter int ALU_W  = 8;
    parameter int CWR_W  = 9;
    parameter int MEM_W  = 3;
    parameter int BSEL_W = 4;
    parameter int NUM_BSRC = 9;
    parameter int WORD_W = ADDR_W + JAM_W + ALU_W + CWR_W + MEM_W + BSEL_W;

    // Field order from MSB down is decoded by the neighbours; keep it.
    typedef struct packed {
        logic [ADDR_W-1:0] next_addr;
        logic              jmpc;
        logic              jamn;
        logic              jamz;
        logic [ALU_W-1:0]  alu;
        logic [CWR_W-1:0]  cwr;
        logic              mem_wr;
        logic              mem_rd;
        logic              mem_fetch;
        logic [BSEL_W-1:0] bsel;
    } uword_t;

    typedef enum logic [1:0] {
        PH_BOOT = 2'd0,
        PH_EXEC = 2'd1,
        PH_ADV  = 2'd2
    } phase_e;

    typedef struct packed {
        phase_e            phase;
        logic [ADDR_W-1:0] mpc;
        uword_t            mir;
        logic              n;
        logic              z;
    } seq_state_t;
endpackage

// File: rtl/useq_store.sv
`timescale 1ns/1ps
module useq_store #(
    parameter int ADDR_W = 9,
    parameter int WORD_W = 36
) (
    input  logic              clk,
    input  logic              we,
    input  logic [ADDR_W-1:0] waddr,
    input  logic [WORD_W-1:0] wdata,
    input  logic [ADDR_W-1:0] raddr,
    output logic [WORD_W-1:0] rdata
);
    localparam int DEPTH = 1 << ADDR_W;

    logic [WORD_W-1:0] mem_q [DEPTH];

    always_ff @(posedge clk) begin
        if (we) begin
            mem_q[waddr] <= wdata;
        end
    end

    assign rdata = mem_q[raddr];
endmodule

// File: rtl/useq_next_addr.sv
`timescale 1ns/1ps
module useq_next_addr
    import useq_pkg::*;
(
    input  uword_t            word,
    input  logic              n_flag,
    input  logic              z_flag,
    input  logic [BYTE_W-1:0] byte_in,
    output logic [ADDR_W-1:0] next_addr
);
    always_comb begin
        next_addr[ADDR_W-1] = (word.jamz & z_flag) | (word.jamn & n_flag)
                            | word.next_addr[ADDR_W-1];
        if (word.jmpc) begin
            next_addr[BYTE_W-1:0] = word.next_addr[BYTE_W-1:0] | byte_in;
        end else begin
            next_addr[BYTE_W-1:0] = word.next_addr[BYTE_W-1:0];
        end
    end
endmodule

// File: rtl/useq_bsel_dec.sv
`timescale 1ns/1ps
module useq_bsel_dec #(
    parameter int SEL_W   = 4,
    parameter int NUM_OUT = 9
) (
    input  logic [SEL_W-1:0]   sel,
    input  logic               en,
    output logic [NUM_OUT-1:0] onehot
);
    for (genvar g = 0; g < NUM_OUT; g++) begin : g_src
        assign onehot[g] = en && (sel == SEL_W'(g));
    end
endmodule

// File: rtl/micro_sequencer.sv
`timescale 1ns/1ps
module micro_sequencer
    import useq_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic              cs_we,
    input  logic [ADDR_W-1:0] cs_waddr,
    input  logic [WORD_W-1:0] cs_wdata,
    input  logic              alu_neg,
    input  logic              alu_zero,
    input  logic [BYTE_W-1:0] mbr_byte,
    output logic              exec_valid,
    output logic [ADDR_W-1:0] cur_addr,
    output logic [ALU_W-1:0]  alu_ctl,
    output logic [CWR_W-1:0]  c_wr_en,
    output logic              mem_write,
    output logic              mem_read,
    output logic              mem_fetch,
    output logic [NUM_BSRC-1:0] b_drive_en
);
    seq_state_t        s_q, s_d;
    logic [ADDR_W-1:0] nxt_addr;
    logic [ADDR_W-1:0] rd_addr;
    logic [WORD_W-1:0] rd_word;
    logic              advancing;

    assign advancing = (s_q.phase == PH_ADV);
    assign rd_addr   = advancing ? nxt_addr : s_q.mpc;

    useq_store #(
        .ADDR_W (ADDR_W),
        .WORD_W (WORD_W)
    ) u_store (
        .clk   (clk),
        .we    (cs_we),
        .waddr (cs_waddr),
        .wdata (cs_wdata),
        .raddr (rd_addr),
        .rdata (rd_word)
    );

    useq_next_addr u_next (
        .word      (s_q.mir),
        .n_flag    (s_q.n),
        .z_flag    (s_q.z),
        .byte_in   (mbr_byte),
        .next_addr (nxt_addr)
    );

    // Next-state logic
    always_comb begin
        s_d = s_q;
        unique case (s_q.phase)
            PH_BOOT: begin
                s_d.mir   = uword_t'(rd_word);
                s_d.phase = PH_EXEC;
            end
            PH_EXEC: begin
                s_d.n     = alu_neg;
                s_d.z     = alu_zero;
                s_d.phase = PH_ADV;
            end
            PH_ADV: begin
                s_d.mpc   = nxt_addr;
                s_d.mir   = uword_t'(rd_word);
                s_d.phase = PH_EXEC;
            end
            default: begin
                s_d.phase = PH_BOOT;
            end
        endcase
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            s_q.phase <= PH_BOOT;
            s_q.mpc   <= '0;
            s_q.mir   <= '0;
            s_q.n     <= 1'b0;
            s_q.z     <= 1'b0;
        end else begin
            s_q <= s_d;
        end
    end

    assign exec_valid = (s_q.phase == PH_EXEC);
    assign cur_addr   = s_q.mpc;
    assign alu_ctl    = exec_valid ? s_q.mir.alu : '0;
    assign c_wr_en    = exec_valid ? s_q.mir.cwr : '0;
    assign mem_write  = exec_valid & s_q.mir.mem_wr;
    assign mem_read   = exec_valid & s_q.mir.mem_rd;
    assign mem_fetch  = exec_valid & s_q.mir.mem_fetch;

    useq_bsel_dec #(
        .SEL_W   (BSEL_W),
        .NUM_OUT (NUM_BSRC)
    ) u_bdec (
        .sel    (s_q.mir.bsel),
        .en     (exec_valid),
        .onehot (b_drive_en)
    );
endmodule

// File: rtl/micro_sequencer_chk.sv
`timescale 1ns/1ps
module micro_sequencer_chk
    import useq_pkg::*;
(
    input logic                clk,
    input logic                rst_n,
    input logic                exec_valid,
    input logic                advancing,
    input uword_t              mir,
    input logic                alu_neg,
    input logic                alu_zero,
    input logic [BYTE_W-1:0]   mbr_byte,
    input logic [ADDR_W-1:0]   cur_addr,
    input logic [ALU_W-1:0]    alu_ctl,
    input logic [CWR_W-1:0]    c_wr_en,
    input logic                mem_write,
    input logic                mem_read,
    input logic                mem_fetch,
    input logic [NUM_BSRC-1:0] b_drive_en
);
    // R2
    exec_then_adv_chk: assert property (@(posedge clk) disable iff (!rst_n)
        exec_valid |=> !exec_valid);

    // R2
    idle_then_exec_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !exec_valid |=> exec_valid);

    // R8
    bsrc_onehot_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0(b_drive_en));

    // R9
    idle_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !exec_valid |-> (alu_ctl == '0 && c_wr_en == '0 && !mem_write
                         && !mem_read && !mem_fetch && b_drive_en == '0));

    // R3
    plain_succ_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (advancing && !mir.jmpc && !mir.jamn && !mir.jamz)
        |=> cur_addr == $past(mir.next_addr));

    // R4
    zero_jump_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (exec_valid && mir.jamz && alu_zero) |=> ##1 cur_addr[ADDR_W-1]);

    // R5
    neg_jump_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (exec_valid && mir.jamn && alu_neg) |=> ##1 cur_addr[ADDR_W-1]);

    // R7
    dispatch_low_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (advancing && mir.jmpc)
        |=> cur_addr[BYTE_W-1:0] == ($past(mir.next_addr[BYTE_W-1:0]) | $past(mbr_byte)));
endmodule

bind micro_sequencer micro_sequencer_chk u_chk (
    .clk        (clk),
    .rst_n      (rst_n),
    .exec_valid (exec_valid),
    .advancing  (advancing),
    .mir        (s_q.mir),
    .alu_neg    (alu_neg),
    .alu_zero   (alu_zero),
    .mbr_byte   (mbr_byte),
    .cur_addr   (cur_addr),
    .alu_ctl    (alu_ctl),
    .c_wr_en    (c_wr_en),
    .mem_write  (mem_write),
    .mem_read   (mem_read),
    .mem_fetch  (mem_fetch),
    .b_drive_en (b_drive_en)
);

// File: tb/micro_sequencer_tb.sv
`timescale 1ns/1ps
module micro_sequencer_tb;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        cs_we = 1'b0;
    logic [8:0]  cs_waddr = '0;
    logic [35:0] cs_wdata = '0;
    logic        alu_neg = 1'b0;
    logic        alu_zero = 1'b0;
    logic [7:0]  mbr_byte = '0;
    logic        exec_valid;
    logic [8:0]  cur_addr;
    logic [7:0]  alu_ctl;
    logic [8:0]  c_wr_en;
    logic        mem_write, mem_read, mem_fetch;
    logic [8:0]  b_drive_en;

    int n_checks = 0;
    int n_fails  = 0;
    bit done     = 1'b0;

    always #4 clk = ~clk;

    micro_sequencer u_dut (
        .clk(clk), .rst_n(rst_n), .cs_we(cs_we), .cs_waddr(cs_waddr),
        .cs_wdata(cs_wdata), .alu_neg(alu_neg), .alu_zero(alu_zero),
        .mbr_byte(mbr_byte), .exec_valid(exec_valid), .cur_addr(cur_addr),
        .alu_ctl(alu_ctl), .c_wr_en(c_wr_en), .mem_write(mem_write),
        .mem_read(mem_read), .mem_fetch(mem_fetch), .b_drive_en(b_drive_en)
    );

    task automatic check(input bit ok, input string req, input string what,
                         input logic [63:0] act, input logic [63:0] exp);
        n_checks++;
        if (!ok) begin
            n_fails++;
            $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
        end
    endtask

    // Arithmetic pattern for the store contents
    function automatic logic [35:0] pattern(input int a);
        logic [8:0] na  = 9'(a * 37 + 5);
        logic [2:0] jam = 3'(a * 5 + 1);
        logic [7:0] alu = 8'(a * 3 + 7);
        logic [8:0] cw  = 9'(a * 11 + 3);
        logic [2:0] mem = 3'(a * 3 + a / 8);
        logic [3:0] bs  = 4'(a * 7 + a / 16);
        return {na, jam, alu, cw, mem, bs};
    endfunction

    function automatic logic [8:0] bdec(input logic [3:0] code);
        return (code < 4'd9) ? 9'(9'd1 << code) : 9'd0;
    endfunction

    function automatic string jtag(input logic [2:0] jam);
        if (jam[2]) return "R7";
        if (jam[1] && jam[0]) return "R6";
        if (jam[0]) return "R4";
        if (jam[1]) return "R5";
        return "R3";
    endfunction

    task automatic check_exec(input logic [35:0] w, input logic [8:0] addr, input string atag);
        check(exec_valid == 1'b1, "R2", "exec_valid in execute cycle", 64'(exec_valid), 64'd1);
        check(cur_addr == addr, atag, "counter", 64'(cur_addr), 64'(addr));
        check(alu_ctl == w[23:16], "R9", "alu_ctl", 64'(alu_ctl), 64'(w[23:16]));
        check(c_wr_en == w[15:7], "R9", "c_wr_en", 64'(c_wr_en), 64'(w[15:7]));
        check({mem_write, mem_read, mem_fetch} == w[6:4], "R9", "memory strobes",
              64'({mem_write, mem_read, mem_fetch}), 64'(w[6:4]));
        check(b_drive_en == bdec(w[3:0]), "R8", "b_drive_en",
              64'(b_drive_en), 64'(bdec(w[3:0])));
    endtask

    task automatic check_quiet(input string req);
        check(exec_valid == 1'b0, req, "exec_valid low", 64'(exec_valid), 64'd0);
        check(alu_ctl == '0 && c_wr_en == '0 && b_drive_en == '0
              && !mem_write && !mem_read && !mem_fetch, req, "controls quiet",
              64'({alu_ctl, c_wr_en, b_drive_en, mem_write, mem_read, mem_fetch}), 64'd0);
    endtask

    function automatic logic [8:0] predict(input logic [35:0] w, input logic n,
                                           input logic z, input logic [7:0] b);
        logic [8:0] na = w[35:27];
        logic [8:0] r;
        r[8]   = (w[24] & z) | (w[25] & n) | na[8];
        r[7:0] = w[26] ? (na[7:0] | b) : na[7:0];
        return r;
    endfunction

    initial begin : main
        logic [15:0] lfsr;
        logic [8:0]  addr;
        logic [35:0] w;
        logic        n, z;
        logic [7:0]  b;
        lfsr = 16'hACE1;
        // R10: fill the store while reset is held
        for (int a = 0; a < 512; a++) begin
            @(negedge clk);
            cs_we = 1'b1; cs_waddr = 9'(a); cs_wdata = pattern(a);
        end
        @(negedge clk);
        cs_we = 1'b0;
        // R1: reset state
        check(cur_addr == 9'd0, "R1", "counter in reset", 64'(cur_addr), 64'd0);
        check_quiet("R1");
        rst_n = 1'b1;
        addr = 9'd0;
        for (int step = 0; step < 3000; step++) begin
            @(posedge clk); @(negedge clk);
            w = pattern(int'(addr));
            check_exec(w, addr, (step == 0) ? "R1" : jtag(w[26:24]));
            lfsr = {lfsr[14:0], lfsr[15] ^ lfsr[13] ^ lfsr[12] ^ lfsr[10]};
            n = lfsr[3]; z = lfsr[9];
            alu_neg = n; alu_zero = z;
            @(posedge clk); @(negedge clk);
            check_quiet("R9");
            b = (step % 5 == 0) ? 8'hFF : lfsr[7:0];
            if (step % 7 == 3) b = 8'h00;
            mbr_byte = b;
            addr = predict(w, n, z, b);
        end
        // R10 directed rewrite: all jump bits, unused select code
        @(negedge clk);
        rst_n = 1'b0;
        cs_we = 1'b1; cs_waddr = 9'd0;
        cs_wdata = {9'h0A5, 3'b111, 8'h5A, 9'h1FF, 3'b101, 4'd15};
        @(negedge clk);
        cs_we = 1'b0;
        @(negedge clk);
        check(cur_addr == 9'd0, "R1", "counter after second reset", 64'(cur_addr), 64'd0);
        rst_n = 1'b1;
        @(posedge clk); @(negedge clk);
        check_exec({9'h0A5, 3'b111, 8'h5A, 9'h1FF, 3'b101, 4'd15}, 9'd0, "R10");
        alu_neg = 1'b0; alu_zero = 1'b0;
        @(posedge clk); @(negedge clk);
        mbr_byte = 8'h5A;
        @(posedge clk); @(negedge clk);
        // R7: 0xA5 | 0x5A = 0xFF, top bit stays 0 with both flags low (R6)
        check(cur_addr == 9'h0FF, "R7", "dispatch result", 64'(cur_addr), 64'h0FF);
        done = 1'b1;
        $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fails);
        $finish;
    end

    initial begin : watchdog
        repeat (150000) @(posedge clk);
        if (!done) begin
            n_checks++;
            n_fails++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fails);
            $finish;
        end
    end
endmodule